// File: doc/BRIEF.md
# Sleep Control Register with Shutdown Decode

This block holds a 16-bit power-management control word behind a small byte-addressed port. Software may update or inspect the word one byte at a time or as a full 16-bit word. The stored word carries an interrupt-enable flag (bit 0) and a 3-bit sleep-type field (bits 12:10). Two bits act as commands only and never read back as one: a release bit (bit 2) and a sleep-go bit (bit 13).

When a write that carries the upper byte sets sleep-go and selects a sleep type of 6 or 7, the block raises `shutdownReq` for exactly one cycle, registered on the clock edge that takes the write. A power sequencer outside this block acts on that pulse. Writes that touch only the low byte can never raise the pulse.

The low byte sits at byte offset `REG_OFFSET` and the high byte at `REG_OFFSET+1`. At the low offset, `byteEn[0]` selects the low lane (`wrData[7:0]`/`rdData[7:0]`) and `byteEn[1]` selects the high lane (`wrData[15:8]`/`rdData[15:8]`), so a word access uses `byteEn = 2'b11`. At the high offset, only `byteEn = 2'b01` is a valid access, and the upper byte then travels on lane 0.

Top module: `pmSleepCtl`

## Requirements
- R1: After reset the stored word is 16'h0001 and `shutdownReq` is 0.
- R2: A read at offset `REG_OFFSET` with `byteEn=2'b11` returns the stored word with bit 2 and bit 13 forced to 0, in the same cycle as `rdEn`.
- R3: A byte read returns only the selected lane and zero elsewhere. At `REG_OFFSET`, `byteEn=2'b01` gives bits 7:0 on `rdData[7:0]` and `byteEn=2'b10` gives bits 15:8 on `rdData[15:8]`. At `REG_OFFSET+1`, `byteEn=2'b01` gives bits 15:8 on `rdData[7:0]`. Bits 2 and 13 always read as 0.
- R4: A word write (`REG_OFFSET`, `byteEn=2'b11`) stores `wrData` with bit 13 cleared.
- R5: A low-byte-only write (`REG_OFFSET`, `byteEn=2'b01`) replaces bits 7:0, keeps bits 15:8 and never produces a shutdown pulse.
- R6: A high-byte-only write (`REG_OFFSET+1` with `byteEn=2'b01` and data on lane 0, or `REG_OFFSET` with `byteEn=2'b10` and data on lane 1) replaces bits 15:8 with the new byte with bit 13 cleared, and keeps bits 7:0.
- R7: A write carrying the high byte whose new bit 13 is 1 and whose new bits 12:10 equal 6 or 7 makes `shutdownReq` 1 in the cycle after the write strobe.
- R8: A write carrying the high byte with bit 13 set and any other sleep type makes no pulse, and its other bits are still stored.
- R9: An access to any other offset, an access with `byteEn=2'b00`, or an access at `REG_OFFSET+1` with `byteEn` other than 2'b01 changes nothing, and a read of that kind returns 0.
- R10: With `rdEn` low, `rdData` is 0.
- R11: Each qualifying write produces a pulse of exactly one cycle. The pulse is 0 again on the next cycle unless another qualifying write follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| wrEn | input | 1 | Write strobe |
| rdEn | input | 1 | Read strobe |
| addr | input | ADDR_W | Byte offset within the block |
| byteEn | input | 2 | Lane enables |
| wrData | input | 16 | Write data |
| rdData | output | 16 | Read data, valid in the same cycle as rdEn |
| shutdownReq | output | 1 | One-cycle shutdown request pulse |

## Verification
The bench uses the default parameters: `ADDR_W=4` and `REG_OFFSET=4`. With these values, random offsets cover the whole 16-entry space, so accesses to the neighbouring offsets 3 and 6 fall next to the register. Random data is biased toward sleep-go set and sleep types 6 and 7, so qualifying writes arrive on both high-byte paths and on the word path, sometimes back to back. Directed cases then cover the byte lanes, the masked bits and the non-qualifying sleep types.

// File: rtl/pmSleepPkg.sv
package pmSleepPkg;
  localparam int unsigned REG_W        = 16;
  localparam int unsigned BYTE_W       = 8;
  localparam int unsigned SCI_BIT      = 0;
  localparam int unsigned RELEASE_BIT  = 2;
  localparam int unsigned TYPE_LSB     = 10;
  localparam int unsigned TYPE_W       = 3;
  localparam int unsigned SLEEP_GO_BIT = 13;

  localparam logic [REG_W-1:0] RESET_VAL = REG_W'(1) << SCI_BIT;
  // Command-only bits that always read as zero
  localparam logic [REG_W-1:0] CMD_MASK =
      (REG_W'(1) << RELEASE_BIT) | (REG_W'(1) << SLEEP_GO_BIT);
  localparam logic [REG_W-1:0] GO_MASK = REG_W'(1) << SLEEP_GO_BIT;

  // Sleep types that mean power-off
  localparam logic [TYPE_W-1:0] OFF_TYPE_A = 3'd6;
  localparam logic [TYPE_W-1:0] OFF_TYPE_B = 3'd7;

  // Strobes from the address decode to the datapath
  typedef struct packed {
    logic loWr;        // write low byte from lane 0
    logic hiWr;        // write high byte
    logic hiFromLane0; // high-byte data arrives on lane 0
    logic loRd;        // drive low byte on lane 0
    logic hiRd;        // drive high byte on lane 1
    logic hiToLane0;   // drive high byte on lane 0
  } laneCmd_t;
endpackage

// File: rtl/pmSleepDecode.sv
module pmSleepDecode
  import pmSleepPkg::*;
#(
  parameter int unsigned ADDR_W     = 4,
  parameter int unsigned REG_OFFSET = 4
) (
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        byteEn,
  output laneCmd_t          cmd
);
  localparam logic [ADDR_W-1:0] LO_ADDR = ADDR_W'(REG_OFFSET);
  localparam logic [ADDR_W-1:0] HI_ADDR = ADDR_W'(REG_OFFSET + 1);

  logic hitLo;
  logic hitHi;

  always_comb begin
    hitLo = (addr == LO_ADDR);
    // upper byte reached directly only as a single lane-0 byte
    hitHi = (addr == HI_ADDR) && (byteEn == 2'b01);

    cmd.loWr        = wrEn & hitLo & byteEn[0];
    cmd.hiWr        = wrEn & ((hitLo & byteEn[1]) | hitHi);
    cmd.hiFromLane0 = wrEn & hitHi;
    cmd.loRd        = rdEn & hitLo & byteEn[0];
    cmd.hiRd        = rdEn & hitLo & byteEn[1];
    cmd.hiToLane0   = rdEn & hitHi;
  end
endmodule

// File: rtl/pmSleepRegs.sv
module pmSleepRegs
  import pmSleepPkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  laneCmd_t         cmd,
  input  logic [REG_W-1:0] wrData,
  output logic [REG_W-1:0] rdData,
  output logic             shutdownReq
);
  localparam int unsigned HI_GO_BIT   = SLEEP_GO_BIT - BYTE_W;
  localparam int unsigned HI_TYPE_LSB = TYPE_LSB - BYTE_W;

  logic [REG_W-1:0]  stored;
  logic [REG_W-1:0]  nextWord;
  logic [REG_W-1:0]  visible;
  logic [BYTE_W-1:0] hiByteIn;
  logic [TYPE_W-1:0] hiType;
  logic              fire;

  function automatic logic isOffType(input logic [TYPE_W-1:0] t);
    return (t == OFF_TYPE_A) || (t == OFF_TYPE_B);
  endfunction

  always_comb begin
    hiByteIn = cmd.hiFromLane0 ? wrData[BYTE_W-1:0] : wrData[REG_W-1:BYTE_W];
    hiType   = hiByteIn[HI_TYPE_LSB +: TYPE_W];
    nextWord = stored;
    if (cmd.loWr) nextWord[BYTE_W-1:0]     = wrData[BYTE_W-1:0];
    if (cmd.hiWr) nextWord[REG_W-1:BYTE_W] = hiByteIn;
    // only the shifted high byte can request power-off
    fire = cmd.hiWr && hiByteIn[HI_GO_BIT] && isOffType(hiType);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stored      <= RESET_VAL;
      shutdownReq <= 1'b0;
    end else begin
      if (cmd.loWr || cmd.hiWr) stored <= nextWord & ~GO_MASK;
      shutdownReq <= fire;
    end
  end

  always_comb begin
    visible = stored & ~CMD_MASK;
    rdData  = '0;
    if (cmd.loRd)      rdData[BYTE_W-1:0]     = visible[BYTE_W-1:0];
    if (cmd.hiRd)      rdData[REG_W-1:BYTE_W] = visible[REG_W-1:BYTE_W];
    if (cmd.hiToLane0) rdData[BYTE_W-1:0]     = visible[REG_W-1:BYTE_W];
  end

  // R5
  lo_only_no_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cmd.loWr && !cmd.hiWr) |=> !shutdownReq);

  // R5
  lo_keeps_upper_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cmd.loWr && !cmd.hiWr) |=> (stored[REG_W-1:BYTE_W] == $past(stored[REG_W-1:BYTE_W])));

  // R6
  hi_keeps_lower_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cmd.hiWr && !cmd.loWr) |=> (stored[BYTE_W-1:0] == $past(stored[BYTE_W-1:0])));

  // R9
  idle_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(cmd.loWr || cmd.hiWr) |=> $stable(stored));

  // R11
  single_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    (shutdownReq && !cmd.hiWr) |=> !shutdownReq);

  // R7
  pulse_source_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(shutdownReq) |-> $past(cmd.hiWr));

  // R9
  lane0_exclusive_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmd.hiFromLane0 |-> (cmd.hiWr && !cmd.loWr));
endmodule

// File: rtl/pmSleepCtl.sv
module pmSleepCtl
  import pmSleepPkg::*;
#(
  parameter int unsigned ADDR_W     = 4,
  parameter int unsigned REG_OFFSET = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        byteEn,
  input  logic [15:0]       wrData,
  output logic [15:0]       rdData,
  output logic              shutdownReq
);
  laneCmd_t cmd;

  pmSleepDecode #(
    .ADDR_W     (ADDR_W),
    .REG_OFFSET (REG_OFFSET)
  ) uDecode (
    .wrEn   (wrEn),
    .rdEn   (rdEn),
    .addr   (addr),
    .byteEn (byteEn),
    .cmd    (cmd)
  );

  pmSleepRegs uRegs (
    .clk         (clk),
    .rstN        (rstN),
    .cmd         (cmd),
    .wrData      (wrData),
    .rdData      (rdData),
    .shutdownReq (shutdownReq)
  );

  // R10
  idle_read_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    !rdEn |-> (rdData == 16'h0000));
endmodule

// File: tb/tb_pmSleepCtl.sv
`timescale 1ns/1ps
module tb_pmSleepCtl;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic        rdEn = 1'b0;
  logic [3:0]  addr = '0;
  logic [1:0]  byteEn = '0;
  logic [15:0] wrData = '0;
  logic [15:0] rdData;
  logic        shutdownReq;

  int checks = 0;
  int fails  = 0;
  logic [15:0] model;

  always #4 clk = ~clk;

  pmSleepCtl #(.ADDR_W(4), .REG_OFFSET(4)) dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .byteEn(byteEn), .wrData(wrData), .rdData(rdData), .shutdownReq(shutdownReq)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // which byte, if any, a write delivers to the upper half
  function automatic logic hiValid(input logic [3:0] a, input logic [1:0] be);
    return (a == 4'd5 && be == 2'b01) || (a == 4'd4 && be[1]);
  endfunction

  function automatic logic [7:0] hiData(input logic [3:0] a, input logic [15:0] d);
    return (a == 4'd5) ? d[7:0] : d[15:8];
  endfunction

  function automatic logic expFire(input logic [3:0] a, input logic [1:0] be, input logic [15:0] d);
    logic [7:0] h;
    h = hiData(a, d);
    return hiValid(a, be) && h[5] && (h[4:2] == 3'd6 || h[4:2] == 3'd7);
  endfunction

  function automatic logic [15:0] modelWrite(input logic [15:0] cur, input logic [3:0] a,
                                             input logic [1:0] be, input logic [15:0] d);
    logic [15:0] n;
    n = cur;
    if (a == 4'd4 && be[0]) n[7:0] = d[7:0];
    if (hiValid(a, be)) n[15:8] = hiData(a, d);
    n[13] = 1'b0;
    return n;
  endfunction

  function automatic logic [15:0] expRead(input logic [15:0] cur, input logic [3:0] a,
                                          input logic [1:0] be);
    logic [15:0] m;
    logic [15:0] r;
    m = cur & 16'hDFFB;
    r = '0;
    if (a == 4'd4) begin
      if (be[0]) r[7:0]  = m[7:0];
      if (be[1]) r[15:8] = m[15:8];
    end else if (a == 4'd5 && be == 2'b01) begin
      r[7:0] = m[15:8];
    end
    return r;
  endfunction

  task automatic doRead(input string req, input logic [3:0] a, input logic [1:0] be);
    @(negedge clk);
    addr = a; byteEn = be; rdEn = 1'b1;
    #1;
    check(req, rdData, expRead(model, a, be));
    rdEn = 1'b0;
    #1;
    check("R10", rdData, 16'h0000);
  endtask

  task automatic doWrite(input string req, input logic [3:0] a, input logic [1:0] be,
                         input logic [15:0] d);
    logic f;
    f = expFire(a, be, d);
    @(negedge clk);
    addr = a; byteEn = be; wrData = d; wrEn = 1'b1;
    @(posedge clk);
    @(negedge clk);
    wrEn = 1'b0;
    model = modelWrite(model, a, be, d);
    check(f ? "R7" : req, {15'd0, shutdownReq}, {15'd0, f});
    if (f) begin
      @(negedge clk);
      check("R11", {15'd0, shutdownReq}, 16'h0000);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    model = 16'h0001;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1 reset state
    check("R1", {15'd0, shutdownReq}, 16'h0000);
    doRead("R1", 4'd4, 2'b11);
    // R2 masked word read
    doWrite("R4", 4'd4, 2'b11, 16'hFFFF);
    doRead("R2", 4'd4, 2'b11);
    check("R2", dut.rdData, 16'h0000);
    doRead("R3", 4'd4, 2'b01);
    doRead("R3", 4'd4, 2'b10);
    doRead("R3", 4'd5, 2'b01);
    // R5 low byte only, with upper bits that would qualify
    doWrite("R5", 4'd4, 2'b01, 16'hFFA5);
    doRead("R5", 4'd4, 2'b11);
    // R6 high byte via offset 5, no go bit
    doWrite("R6", 4'd5, 2'b01, 16'h0018);
    doRead("R6", 4'd4, 2'b11);
    // R7 both high paths and word, types 6 and 7
    doWrite("R7", 4'd5, 2'b01, 16'h0038);
    doWrite("R7", 4'd4, 2'b10, 16'h3C00);
    doWrite("R7", 4'd4, 2'b11, 16'h3801);
    doRead("R4", 4'd4, 2'b11);
    // R8 go with other types
    for (int t = 0; t < 6; t++) begin
      doWrite("R8", 4'd5, 2'b01, 16'(8'h20 | (t << 2)));
      doRead("R8", 4'd5, 2'b01);
    end
    // R9 ignored accesses
    doWrite("R9", 4'd3, 2'b11, 16'h3C00);
    doWrite("R9", 4'd6, 2'b01, 16'h00FF);
    doWrite("R9", 4'd5, 2'b11, 16'h3C3C);
    doWrite("R9", 4'd4, 2'b00, 16'hFFFF);
    doRead("R9", 4'd4, 2'b11);
    doRead("R9", 4'd5, 2'b10);
    doRead("R9", 4'd6, 2'b11);
    // R11 back-to-back qualifying writes
    @(negedge clk);
    addr = 4'd5; byteEn = 2'b01; wrData = 16'h0038; wrEn = 1'b1;
    @(negedge clk);
    check("R11", {15'd0, shutdownReq}, 16'h0001);
    wrData = 16'h003C;
    @(negedge clk);
    wrEn = 1'b0;
    check("R11", {15'd0, shutdownReq}, 16'h0001);
    @(negedge clk);
    check("R11", {15'd0, shutdownReq}, 16'h0000);
    model = modelWrite(model, 4'd5, 2'b01, 16'h003C);
    // random mix
    for (int i = 0; i < 400; i++) begin
      logic [3:0]  a;
      logic [1:0]  be;
      logic [15:0] d;
      a  = ($urandom_range(0, 3) != 0) ? 4'(3 + $urandom_range(0, 3)) : 4'($urandom_range(0, 15));
      be = 2'($urandom_range(0, 3));
      d  = 16'($urandom);
      if ($urandom_range(0, 1) != 0) begin
        d[13] = 1'b1; d[5] = 1'b1;
        d[12] = 1'b1; d[11] = 1'b1; d[4] = 1'b1; d[3] = 1'b1;
      end
      if ($urandom_range(0, 1) != 0) doWrite("R4", a, be, d);
      else doRead("R3", a, be);
      if (i % 8 == 0) doRead("R2", 4'd4, 2'b11);
    end
    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule